// File: doc/BRIEF.md
# DMA Transfer Address Generator

This block produces the memory address for each single transfer made by a four-channel DMA controller. A transfer engine presents a request that names a channel and says whether the transfer writes memory or reads it. In the same cycle the block answers with a 24-bit physical address and a result code. It holds each channel's 16-bit current address, its 16-bit remaining count and its completion flag. On an accepted request it steps the address up or down and counts the count down.

The upper byte of the physical address comes from a small file of page registers. These are written through a scrambled 3-bit index, and the first four slots feed channels 0 to 3. The transfer type and the direction flag of each channel come in from the mode logic outside the block. A load port programs a channel's address and count before a run, and an external completion strobe can mark a channel finished.

Top module: `dma_addr_gen`

## Requirements
- R1: A request is accepted only when `req_write_i`=1 and the channel's type field is 1 (write), or when `req_write_i`=0 and the type is 2 (read). Types 0 (verify) and 3 (invalid) accept nothing. A refused request, or a cycle with no request, returns code 0 and address 0 and leaves the channel's address, count and flag as they were.
- R2: An accepted request returns the channel's current 16-bit address in bits 15:0. The address then moves by one, down when that channel's `decr_i` bit is 1 and up otherwise. It wraps modulo 2^16 and never carries into or borrows from bits 23:16.
- R3: Each accepted request decrements the channel's 16-bit count. The channel's flag in `done_o` becomes 1 from the next cycle when the count wraps from 0 to 0xFFFF.
- R4: Code 2 (accepted with end-of-process) is returned only when the channel's flag was 0 before the request and the request wraps the count. Every other accepted request returns code 1. The flag stays set, so a finished channel keeps accepting with code 1. Code 3 never appears.
- R5: Bits 23:16 of the physical address hold the page value of the requested channel.
- R6: A page write with index 7, 3, 1 or 2 sets the page of channel 0, 1, 2 or 3 respectively. Index 0, 4, 5 or 6 fills a slot that no channel reads, so no channel's page changes.
- R7: A 1 on `force_done_i[c]` sets channel c's flag from the next cycle. Later requests to that channel return code 1 even when the count wraps.
- R8: A load sets the channel's address and count and clears its flag from the next cycle. A completion strobe on the same channel in the same cycle wins over the clear.
- R9: After reset, every address, count, page and flag is 0. The first accepted request to a channel therefore returns address 0 with code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Transfer request present |
| req_ch_i | input | 2 | Requested channel |
| req_write_i | input | 1 | 1 = memory write transfer, 0 = memory read transfer |
| xfer_type_i | input | 8 | Two-bit transfer type per channel, channel c in bits 2c+1:2c |
| decr_i | input | 4 | Per-channel address direction, 1 = count down |
| resp_addr_o | output | 24 | Physical address (page in 23:16) |
| resp_code_o | output | 2 | 0 refused, 1 accepted, 2 accepted with end-of-process |
| load_valid_i | input | 1 | Load a channel's address and count |
| load_ch_i | input | 2 | Channel to load |
| load_addr_i | input | 16 | Start address |
| load_count_i | input | 16 | Start count |
| page_we_i | input | 1 | Page register write |
| page_idx_i | input | 3 | Page port index |
| page_data_i | input | 8 | Page value |
| force_done_i | input | 4 | Per-channel completion strobe |
| done_o | output | 4 | Per-channel completion flags |

## Verification
A wrong address or count in a channel shows at the ports the next time that channel is served. A bad address appears at once in bits 15:0 of the response. A bad count shows only where it moves the end-of-process code away from the access that wraps it, which can be many requests later. A wrong completion flag shows up one cycle after the fault in `done_o`, and also as a missing or repeated code 2. A wrong page slot shows in bits 23:16 of the first request to the affected channel.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

    localparam int unsigned PAGE_SLOTS = 8;
    localparam int unsigned SLOT_W     = 3;

    typedef enum logic [1:0] {
        XFER_VERIFY  = 2'd0,
        XFER_WRITE   = 2'd1,
        XFER_READ    = 2'd2,
        XFER_INVALID = 2'd3
    } xfer_e;

    typedef enum logic [1:0] {
        RESP_NONE = 2'd0,
        RESP_OK   = 2'd1,
        RESP_EOP  = 2'd2
    } resp_e;

    // Port index to storage slot; slots 0..3 feed channels 0..3.
    function automatic logic [SLOT_W-1:0] page_slot(input logic [SLOT_W-1:0] idx);
        case (idx)
            3'd7:    page_slot = 3'd0;
            3'd3:    page_slot = 3'd1;
            3'd1:    page_slot = 3'd2;
            3'd2:    page_slot = 3'd3;
            3'd0:    page_slot = 3'd4;
            3'd4:    page_slot = 3'd5;
            3'd5:    page_slot = 3'd6;
            default: page_slot = 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/dma_page_file.sv
module dma_page_file
    import dma_addr_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned PW  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [SLOT_W-1:0] idx_i,
    input  logic [PW-1:0]     data_i,
    output logic [NCH*PW-1:0] pages_o
);

    logic [PAGE_SLOTS-1:0][PW-1:0] slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (wr_i) begin
            slot_d[page_slot(idx_i)] = data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_tap
        assign pages_o[c*PW +: PW] = slot_q[c];
    end

endmodule

// File: rtl/dma_chan_ctx.sv
module dma_chan_ctx #(
    parameter int unsigned AW = 16,
    parameter int unsigned CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          acc_i,
    input  logic          decr_i,
    input  logic          load_i,
    input  logic [AW-1:0] load_addr_i,
    input  logic [CW-1:0] load_cnt_i,
    input  logic          force_i,
    output logic [AW-1:0] addr_o,
    output logic [CW-1:0] cnt_o,
    output logic          done_o
);

    localparam logic [AW-1:0] A_ONE = AW'(1);
    localparam logic [CW-1:0] C_ONE = CW'(1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic          done;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (acc_i) begin
            ctx_d.addr = decr_i ? (ctx_q.addr - A_ONE) : (ctx_q.addr + A_ONE);
            ctx_d.cnt  = ctx_q.cnt - C_ONE;
            ctx_d.done = ctx_q.done | (ctx_q.cnt == '0);
        end
        if (load_i) begin
            ctx_d.addr = load_addr_i;
            ctx_d.cnt  = load_cnt_i;
            ctx_d.done = 1'b0;
        end
        if (force_i) begin
            ctx_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign addr_o = ctx_q.addr;
    assign cnt_o  = ctx_q.cnt;
    assign done_o = ctx_q.done;

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_addr_pkg::*;
#(
    parameter int unsigned NCH  = 4,
    parameter int unsigned AW   = 16,
    parameter int unsigned CW   = 16,
    parameter int unsigned PW   = 8,
    localparam int unsigned CH_W = $clog2(NCH),
    localparam int unsigned PA_W = AW + PW
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [CH_W-1:0]   req_ch_i,
    input  logic              req_write_i,
    input  logic [2*NCH-1:0]  xfer_type_i,
    input  logic [NCH-1:0]    decr_i,
    output logic [PA_W-1:0]   resp_addr_o,
    output logic [1:0]        resp_code_o,
    input  logic              load_valid_i,
    input  logic [CH_W-1:0]   load_ch_i,
    input  logic [AW-1:0]     load_addr_i,
    input  logic [CW-1:0]     load_count_i,
    input  logic              page_we_i,
    input  logic [SLOT_W-1:0] page_idx_i,
    input  logic [PW-1:0]     page_data_i,
    input  logic [NCH-1:0]    force_done_i,
    output logic [NCH-1:0]    done_o
);

    logic [AW-1:0]     ch_addr [NCH];
    logic [CW-1:0]     ch_cnt  [NCH];
    logic [NCH-1:0]    ch_done;
    logic [NCH-1:0]    acc_vec;
    logic [NCH-1:0]    load_vec;
    logic [NCH*PW-1:0] pages;
    logic [PW-1:0]     sel_page;
    xfer_e             sel_type;
    logic              match;

    dma_page_file #(.NCH(NCH), .PW(PW)) u_pages (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (page_we_i),
        .idx_i   (page_idx_i),
        .data_i  (page_data_i),
        .pages_o (pages)
    );

    always_comb begin
        sel_type = xfer_e'(xfer_type_i[req_ch_i*2 +: 2]);
        sel_page = pages[req_ch_i*PW +: PW];
        match    = req_valid_i &&
                   ((req_write_i  && sel_type == XFER_WRITE) ||
                    (!req_write_i && sel_type == XFER_READ));
        if (!match) begin
            resp_addr_o = '0;
            resp_code_o = RESP_NONE;
        end else begin
            resp_addr_o = {sel_page, ch_addr[req_ch_i]};
            resp_code_o = (!ch_done[req_ch_i] && ch_cnt[req_ch_i] == '0) ? RESP_EOP : RESP_OK;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign acc_vec[c]  = match && (req_ch_i == CH_W'(c));
        assign load_vec[c] = load_valid_i && (load_ch_i == CH_W'(c));

        dma_chan_ctx #(.AW(AW), .CW(CW)) u_ctx (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .acc_i       (acc_vec[c]),
            .decr_i      (decr_i[c]),
            .load_i      (load_vec[c]),
            .load_addr_i (load_addr_i),
            .load_cnt_i  (load_count_i),
            .force_i     (force_done_i[c]),
            .addr_o      (ch_addr[c]),
            .cnt_o       (ch_cnt[c]),
            .done_o      (ch_done[c])
        );
    end

    assign done_o = ch_done;

endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
    parameter int unsigned NCH  = 4,
    parameter int unsigned PA_W = 24,
    localparam int unsigned CH_W = $clog2(NCH)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             req_valid_i,
    input logic [CH_W-1:0]  req_ch_i,
    input logic             req_write_i,
    input logic [2*NCH-1:0] xfer_type_i,
    input logic             load_valid_i,
    input logic [CH_W-1:0]  load_ch_i,
    input logic [NCH-1:0]   force_done_i,
    input logic [PA_W-1:0]  resp_addr_o,
    input logic [1:0]       resp_code_o,
    input logic [NCH-1:0]   done_o
);

    logic [1:0] ty;
    logic       dir_ok;
    assign ty     = xfer_type_i[req_ch_i*2 +: 2];
    assign dir_ok = req_write_i ? (ty == 2'd1) : (ty == 2'd2);

    p_refuse_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resp_code_o == 2'd0 |-> resp_addr_o == '0);

    p_refuse_dir_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_valid_i || !dir_ok) |-> resp_code_o == 2'd0);

    p_code_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resp_code_o != 2'd3);

    p_eop_fresh_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resp_code_o == 2'd2 |-> !done_o[req_ch_i]);

    p_eop_marks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resp_code_o == 2'd2 && !(load_valid_i && load_ch_i == req_ch_i))
        |=> done_o[$past(req_ch_i)]);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        p_force_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            force_done_i[c] |=> done_o[c]);

        p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (done_o[c] && !(load_valid_i && load_ch_i == CH_W'(c))) |=> done_o[c]);

        p_load_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (load_valid_i && load_ch_i == CH_W'(c) && !force_done_i[c]) |=> !done_o[c]);
    end

endmodule

bind dma_addr_gen dma_addr_gen_chk #(.NCH(NCH), .PA_W(PA_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ch_i     (req_ch_i),
    .req_write_i  (req_write_i),
    .xfer_type_i  (xfer_type_i),
    .load_valid_i (load_valid_i),
    .load_ch_i    (load_ch_i),
    .force_done_i (force_done_i),
    .resp_addr_o  (resp_addr_o),
    .resp_code_o  (resp_code_o),
    .done_o       (done_o)
);

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb;

    typedef struct packed {
        logic [23:0] addr;
        logic [1:0]  code;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_ch = '0;
    logic        req_write = 1'b0;
    logic [7:0]  xfer_type;
    logic [3:0]  decr = '0;
    logic [23:0] resp_addr;
    logic [1:0]  resp_code;
    logic        load_valid = 1'b0;
    logic [1:0]  load_ch = '0;
    logic [15:0] load_addr = '0;
    logic [15:0] load_count = '0;
    logic        page_we = 1'b0;
    logic [2:0]  page_idx = '0;
    logic [7:0]  page_data = '0;
    logic [3:0]  force_done = '0;
    logic [3:0]  done;

    logic [1:0]  ty_r [4];
    logic [15:0] m_addr [4];
    logic [15:0] m_cnt [4];
    logic [7:0]  m_page [4];
    logic [3:0]  m_done;

    exp_t  exp_q [$];
    string tag_q [$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    always #4 clk = ~clk;

    assign xfer_type = {ty_r[3], ty_r[2], ty_r[1], ty_r[0]};

    dma_addr_gen u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .req_valid_i  (req_valid),
        .req_ch_i     (req_ch),
        .req_write_i  (req_write),
        .xfer_type_i  (xfer_type),
        .decr_i       (decr),
        .resp_addr_o  (resp_addr),
        .resp_code_o  (resp_code),
        .load_valid_i (load_valid),
        .load_ch_i    (load_ch),
        .load_addr_i  (load_addr),
        .load_count_i (load_count),
        .page_we_i    (page_we),
        .page_idx_i   (page_idx),
        .page_data_i  (page_data),
        .force_done_i (force_done),
        .done_o       (done)
    );

    // Index to channel as given by R6; -1 for slots no channel reads.
    function automatic int idx_to_ch(input logic [2:0] idx);
        case (idx)
            3'd7:    return 0;
            3'd3:    return 1;
            3'd1:    return 2;
            3'd2:    return 3;
            default: return -1;
        endcase
    endfunction

    task automatic push(input exp_t e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic start_cycle();
        @(negedge clk);
        req_valid  = 1'b0;
        load_valid = 1'b0;
        page_we    = 1'b0;
        force_done = '0;
    endtask

    task automatic idle(input string tag);
        start_cycle();
        push('{addr: 24'h0, code: 2'd0}, tag);
    endtask

    task automatic do_access(input int ch, input bit wr, input string tag);
        exp_t e;
        bit   ok;
        start_cycle();
        req_valid = 1'b1;
        req_ch    = 2'(ch);
        req_write = wr;
        ok = wr ? (ty_r[ch] == 2'd1) : (ty_r[ch] == 2'd2);
        if (!ok) begin
            e = '{addr: 24'h0, code: 2'd0};
        end else begin
            e.addr = {m_page[ch], m_addr[ch]};
            e.code = (!m_done[ch] && m_cnt[ch] == 16'h0) ? 2'd2 : 2'd1;
            if (m_cnt[ch] == 16'h0) m_done[ch] = 1'b1;
            m_addr[ch] = decr[ch] ? m_addr[ch] - 16'h1 : m_addr[ch] + 16'h1;
            m_cnt[ch]  = m_cnt[ch] - 16'h1;
        end
        push(e, tag);
    endtask

    task automatic do_load(input int ch, input logic [15:0] a, input logic [15:0] n, input string tag);
        start_cycle();
        load_valid = 1'b1;
        load_ch    = 2'(ch);
        load_addr  = a;
        load_count = n;
        m_addr[ch] = a;
        m_cnt[ch]  = n;
        m_done[ch] = 1'b0;
        push('{addr: 24'h0, code: 2'd0}, tag);
    endtask

    task automatic do_page(input logic [2:0] idx, input logic [7:0] v, input string tag);
        int ch;
        start_cycle();
        page_we   = 1'b1;
        page_idx  = idx;
        page_data = v;
        ch = idx_to_ch(idx);
        if (ch >= 0) m_page[ch] = v;
        push('{addr: 24'h0, code: 2'd0}, tag);
    endtask

    task automatic do_force(input int ch, input string tag);
        start_cycle();
        force_done[ch] = 1'b1;
        m_done[ch] = 1'b1;
        push('{addr: 24'h0, code: 2'd0}, tag);
    endtask

    task automatic check_done(input string tag);
        start_cycle();
        n_chk++;
        if (done !== m_done) begin
            n_bad++;
            $display("FAIL %s done_o actual=%b expected=%b", tag, done, m_done);
        end
    endtask

    // Scoreboard monitor: compares each response between clock edges.
    initial begin
        exp_t  e;
        string t;
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (resp_addr !== e.addr || resp_code !== e.code) begin
                    n_bad++;
                    $display("FAIL %s resp actual=%h/%0d expected=%h/%0d",
                             t, resp_addr, resp_code, e.addr, e.code);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            ty_r[c] = 2'd0; m_addr[c] = '0; m_cnt[c] = '0; m_page[c] = '0;
        end
        m_done = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state, idle response is zero (R1)
        check_done("R9 reset flags");
        idle("R1 idle response");

        // R9 / R4: first access after reset wraps count 0 -> code 2 at address 0
        ty_r[0] = 2'd1;
        do_access(0, 1'b1, "R9 first access eop");
        do_access(0, 1'b1, "R4 repeat access plain");
        check_done("R3 flag after wrap");

        // R1: direction / type mismatches
        ty_r[1] = 2'd2;
        do_access(1, 1'b1, "R1 write to read channel");
        ty_r[1] = 2'd0;
        do_access(1, 1'b0, "R1 verify type");
        ty_r[1] = 2'd3;
        do_access(1, 1'b1, "R1 invalid type");
        do_access(0, 1'b0, "R1 read to write channel");

        // R6 / R5: page remap
        do_page(3'd7, 8'h12, "R6 idx7");
        do_page(3'd3, 8'h34, "R6 idx3");
        do_page(3'd1, 8'h56, "R6 idx1");
        do_page(3'd2, 8'h78, "R6 idx2");
        do_page(3'd0, 8'hAA, "R6 idx0");
        do_page(3'd4, 8'hBB, "R6 idx4");
        do_page(3'd5, 8'hCC, "R6 idx5");
        do_page(3'd6, 8'hDD, "R6 idx6");
        do_access(0, 1'b1, "R5 channel 0 page");

        // R3: count of 2 ends on the third access
        ty_r[1] = 2'd2;
        do_load(1, 16'h1000, 16'd2, "R8 load ch1");
        check_done("R8 load ch1 flags");
        do_access(1, 1'b0, "R3 ch1 access 1");
        do_access(1, 1'b0, "R3 ch1 access 2");
        do_access(1, 1'b0, "R3 ch1 access 3 eop");
        check_done("R3 ch1 flag");

        // R2: decrement across zero without page borrow
        ty_r[2] = 2'd1;
        decr[2] = 1'b1;
        do_load(2, 16'h0001, 16'd5, "R8 load ch2");
        do_access(2, 1'b1, "R2 dec 1");
        do_access(2, 1'b1, "R2 dec 2");
        do_access(2, 1'b1, "R2 dec wrap");
        do_access(2, 1'b1, "R2 dec after wrap");

        // R2: increment wrap; R1: refused request leaves state
        ty_r[3] = 2'd1;
        do_load(3, 16'hFFFF, 16'd10, "R8 load ch3");
        do_access(3, 1'b1, "R2 inc at top");
        do_access(3, 1'b1, "R2 inc wrap");
        do_access(3, 1'b0, "R1 refused keeps state");
        do_access(3, 1'b1, "R1 state unchanged after refusal");

        // R7: forced completion suppresses end-of-process
        do_load(3, 16'h0020, 16'd0, "R8 load ch3 zero");
        do_force(3, "R7 force ch3");
        check_done("R7 flag forced");
        do_access(3, 1'b1, "R7 no eop after force");

        // R8: load clears flag, eop returns; force beats load clear
        do_load(3, 16'h0040, 16'd0, "R8 reload ch3");
        check_done("R8 flag cleared");
        do_access(3, 1'b1, "R8 eop after reload");
        start_cycle();
        load_valid = 1'b1; load_ch = 2'd2; load_addr = 16'h0100; load_count = 16'd0;
        force_done[2] = 1'b1;
        m_addr[2] = 16'h0100; m_cnt[2] = 16'd0; m_done[2] = 1'b1;
        check_done("R8 force beats load");
        do_access(2, 1'b1, "R8 forced-on-load no eop");
        check_done("R4 final flags");

        idle("R1 trailing idle");
        idle("R1 trailing idle");
        start_cycle();
        start_cycle();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule